// File: doc/BRIEF.md
# Flash Program Suspend/Resume Controller

This block is the command-level controller for a NOR-style flash program path. It watches a decoded host write bus. A two-write program sequence starts an embedded program operation. A program timer is modelled inside the block and counts the operation down to completion. While a program is running, the host can pause it, look at device identification data, and let it continue.

Only the low byte of the host data is decoded as a command. Address bits never take part in command decoding. The timer is frozen for as long as the operation is suspended, so the number of cycles spent programming does not depend on how often the operation is paused. Identification mode can only be entered from suspend. Leaving it goes back to suspend, not to read mode. Commands that make no sense in the current mode leave the mode unchanged.

Top module: `flash_prog_suspend`

## Requirements
- R1: A synchronous active-high reset forces read mode (mode code 0) and clears any pending operation. busy and progEn read 0. A resume command (low byte 30h) written after the reset leaves the block in read mode.
- R2: In read mode, a write whose low data byte is A0h enters setup mode (code 1). The next write of any value enters programming mode (code 2) and captures its address and full data word on progAddr and progData. busy and progEn are 1 only in programming mode.
- R3: Without interruption, programming mode lasts exactly PROG_CYCLES clock cycles and then returns to read mode.
- R4: A write with low byte B0h in programming mode enters suspend mode (code 3) on the next clock edge. busy and progEn are 0 while suspended.
- R5: The program timer is frozen in suspend and identification modes. The total number of cycles spent in programming mode, summed across all suspensions, equals PROG_CYCLES. The cycle in which the suspend write is taken counts as a programming cycle.
- R6: A write with low byte 30h in suspend mode returns to programming mode. The address bits and data bits 15:8 of that write do not matter.
- R7: Resume writes taken while already in programming mode have no effect: the mode does not change and the completion time does not change.
- R8: Suspend and resume may alternate any number of times within one program operation.
- R9: Suspend, resume, identification-entry (90h) and exit (F0h) writes in read mode leave the block in read mode.
- R10: A write with low byte 90h in suspend mode enters identification mode (code 4). A write with low byte F0h in identification mode returns to suspend mode.
- R11: In identification mode, every write other than F0h, including resume and suspend, leaves the mode unchanged.
- R12: If a suspend write lands on the final programming cycle, completion wins and the block enters read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host write strobe, one write per cycle while high |
| hostAddr | input | ADDR_W | Host write address |
| hostData | input | DATA_W | Host write data; bits 7:0 carry the command |
| mode | output | 3 | Current mode: 0 read, 1 setup, 2 programming, 3 suspend, 4 identification |
| busy | output | 1 | High while the program operation is running |
| progEn | output | 1 | Program engine enable; the timer advances while high |
| progAddr | output | ADDR_W | Address captured by the program write |
| progData | output | DATA_W | Data word captured by the program write |

## Verification
A plain program run sets the reference duration. Runs with one suspend, with several suspend/resume pairs, and with identification mode nested inside a suspend must each end after exactly the remaining number of cycles; this separates a frozen timer from one that keeps counting or restarts. Resume writes during programming and stray commands in read and identification modes show whether redundant commands are truly ignored, not partly acted on. A suspend written on the very last programming cycle shows whether completion takes priority, and a reset during suspend shows whether a pending operation survives the reset.

// File: rtl/fsctl_pkg.sv
package fsctl_pkg;

  typedef enum logic [2:0] {
    MODE_READ  = 3'd0,
    MODE_SETUP = 3'd1,
    MODE_PROG  = 3'd2,
    MODE_SUSP  = 3'd3,
    MODE_IDENT = 3'd4
  } fsMode_e;

  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_EXIT    = 8'hF0;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTimer;
    logic runTimer;
    logic latchWord;
  } dpCtl_t;

  // decoded command hits from datapath to control
  typedef struct packed {
    logic anyWrite;
    logic isProgram;
    logic isSuspend;
    logic isResume;
    logic isIdent;
    logic isExit;
  } cmdHit_t;

endpackage

// File: rtl/fsctl_datapath.sv
module fsctl_datapath
  import fsctl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  dpCtl_t            ctl,
  output cmdHit_t           hit,
  output logic              timerDone,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [7:0]       cmdByte;
  logic [CNT_W-1:0] remain;

  // only the low byte is a command; address never decoded
  assign cmdByte = data[7:0];

  always_comb begin
    hit           = '0;
    hit.anyWrite  = wrEn;
    hit.isProgram = wrEn && (cmdByte == CMD_PROGRAM);
    hit.isSuspend = wrEn && (cmdByte == CMD_SUSPEND);
    hit.isResume  = wrEn && (cmdByte == CMD_RESUME);
    hit.isIdent   = wrEn && (cmdByte == CMD_IDENT);
    hit.isExit    = wrEn && (cmdByte == CMD_EXIT);
  end

  // program timer: counts only while the engine runs
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (ctl.loadTimer) begin
      remain <= CNT_LOAD;
    end else if (ctl.runTimer && (remain != '0)) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign timerDone = ctl.runTimer && (remain == CNT_LAST);

  // program word capture
  always_ff @(posedge clk) begin
    if (rst) begin
      progAddr <= '0;
      progData <= '0;
    end else if (ctl.latchWord) begin
      progAddr <= addr;
      progData <= data;
    end
  end

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!ctl.runTimer && !ctl.loadTimer) |=> $stable(remain)); // R5

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !ctl.latchWord |=> ($stable(progAddr) && $stable(progData))); // R2

endmodule

// File: rtl/fsctl_control.sv
module fsctl_control
  import fsctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  cmdHit_t hit,
  input  logic    timerDone,
  output fsMode_e state,
  output dpCtl_t  ctl
);

  fsMode_e nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      MODE_READ: begin
        if (hit.isProgram) nextState = MODE_SETUP;
      end
      MODE_SETUP: begin
        if (hit.anyWrite) begin
          nextState     = MODE_PROG;
          ctl.loadTimer = 1'b1;
          ctl.latchWord = 1'b1;
        end
      end
      MODE_PROG: begin
        ctl.runTimer = 1'b1;
        if (timerDone)          nextState = MODE_READ;
        else if (hit.isSuspend) nextState = MODE_SUSP;
      end
      MODE_SUSP: begin
        if (hit.isResume)     nextState = MODE_PROG;
        else if (hit.isIdent) nextState = MODE_IDENT;
      end
      MODE_IDENT: begin
        if (hit.isExit) nextState = MODE_SUSP;
      end
      default: nextState = MODE_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= MODE_READ;
    else     state <= nextState;
  end

  AST_SUSPEND_ENTER: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_PROG && hit.isSuspend && !timerDone) |=> (state == MODE_SUSP)); // R4

  AST_DONE_WINS: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_PROG && timerDone) |=> (state == MODE_READ)); // R12

  AST_RESUME_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_SUSP && hit.isResume) |=> (state == MODE_PROG)); // R6

  AST_RESUME_REDUNDANT: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_PROG && hit.isResume && !timerDone) |=> (state == MODE_PROG)); // R7

  AST_READ_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_READ && !hit.isProgram) |=> (state == MODE_READ)); // R9

  AST_IDENT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_IDENT && hit.isExit) |=> (state == MODE_SUSP)); // R10

  AST_IDENT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_IDENT && !hit.isExit) |=> (state == MODE_IDENT)); // R11

endmodule

// File: rtl/flash_prog_suspend.sv
module flash_prog_suspend
  import fsctl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  output logic [2:0]        mode,
  output logic              busy,
  output logic              progEn,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData
);

  cmdHit_t cmdHit;
  dpCtl_t  dpCtl;
  logic    timerDone;
  fsMode_e curMode;

  fsctl_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PROG_CYCLES(PROG_CYCLES)
  ) uDatapath (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (hostWrEn),
    .addr     (hostAddr),
    .data     (hostData),
    .ctl      (dpCtl),
    .hit      (cmdHit),
    .timerDone(timerDone),
    .progAddr (progAddr),
    .progData (progData)
  );

  fsctl_control uControl (
    .clk      (clk),
    .rst      (rst),
    .hit      (cmdHit),
    .timerDone(timerDone),
    .state    (curMode),
    .ctl      (dpCtl)
  );

  assign mode   = curMode;
  assign busy   = (curMode == MODE_PROG);
  assign progEn = dpCtl.runTimer;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (curMode != MODE_PROG) |-> (!progEn && !busy)); // R4

endmodule

// File: tb/tb_flash_prog_suspend.sv
module tb_flash_prog_suspend;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int N  = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hostWrEn = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostData = '0;
  logic [2:0]    mode;
  logic          busy;
  logic          progEn;
  logic [AW-1:0] progAddr;
  logic [DW-1:0] progData;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  flash_prog_suspend #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostData(hostData), .mode(mode), .busy(busy), .progEn(progEn),
    .progAddr(progAddr), .progData(progData)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the following posedge
  task automatic hostWrite(input logic [DW-1:0] d, input logic [AW-1:0] a);
    hostWrEn = 1'b1;
    hostData = d;
    hostAddr = a;
    @(negedge clk);
    hostWrEn = 1'b0;
    hostData = '0;
    hostAddr = '0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic startProgram(input logic [DW-1:0] d, input logic [AW-1:0] a);
    hostWrite(16'h00A0, 16'h0555);
    hostWrite(d, a);
  endtask

  // number of cycles until programming mode is left
  task automatic waitProgEnd(output int n);
    n = 0;
    while (mode == 3'd2 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic tReset();
    chk("R1 mode", mode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 progEn", progEn, 0);
  endtask

  task automatic tPlain();
    int n;
    hostWrite(16'h00A0, 16'h0000);
    chk("R2 setup mode", mode, 1);
    chk("R2 busy in setup", busy, 0);
    hostWrite(16'h5A3C, 16'h1234);
    chk("R2 prog mode", mode, 2);
    chk("R2 busy", busy, 1);
    chk("R2 progEn", progEn, 1);
    chk("R2 progAddr", progAddr, 16'h1234);
    chk("R2 progData", progData, 16'h5A3C);
    waitProgEnd(n);
    chk("R3 duration", n, N);
    chk("R3 back to read", mode, 0);
  endtask

  task automatic tSuspend();
    int n;
    startProgram(16'h1111, 16'h0042);
    repeat (4) @(negedge clk);
    hostWrite(16'h00B0, 16'h7777);
    chk("R4 suspend mode", mode, 3);
    chk("R4 busy low", busy, 0);
    chk("R4 progEn low", progEn, 0);
    repeat (10) @(negedge clk);
    chk("R5 still suspended", mode, 3);
    hostWrite(16'hAB30, 16'hFFFF);
    chk("R6 resume ignores addr/upper", mode, 2);
    waitProgEnd(n);
    chk("R5 remaining cycles", n, N - 5);
  endtask

  task automatic tRepeatResume();
    int n;
    startProgram(16'h2222, 16'h0010);
    repeat (2) @(negedge clk);
    hostWrite(16'h0030, 16'h0000);
    chk("R7 first redundant resume", mode, 2);
    hostWrite(16'h0030, 16'h1234);
    chk("R7 second redundant resume", mode, 2);
    waitProgEnd(n);
    chk("R7 completion unchanged", n, N - 4);
  endtask

  task automatic tAlternate();
    int n;
    startProgram(16'h3333, 16'h0020);
    for (int i = 0; i < 4; i++) begin
      hostWrite(16'h00B0, 16'(i));
      chk("R8 suspend again", mode, 3);
      hostWrite(16'h0030, 16'(i));
      chk("R8 resume again", mode, 2);
    end
    waitProgEnd(n);
    chk("R8 remaining after alternation", n, N - 4);
  endtask

  task automatic tIgnoreRead();
    hostWrite(16'h00B0, 16'h0000);
    chk("R9 suspend in read", mode, 0);
    hostWrite(16'h0030, 16'h0000);
    chk("R9 resume in read", mode, 0);
    hostWrite(16'h0090, 16'h0000);
    chk("R9 ident in read", mode, 0);
    hostWrite(16'h00F0, 16'h0000);
    chk("R9 exit in read", mode, 0);
    chk("R9 progEn low", progEn, 0);
  endtask

  task automatic tIdent();
    int n;
    startProgram(16'h4444, 16'h0030);
    hostWrite(16'h00B0, 16'h0000);
    chk("R4 suspend at first cycle", mode, 3);
    hostWrite(16'h0090, 16'h0555);
    chk("R10 ident entered", mode, 4);
    chk("R10 busy low in ident", busy, 0);
    hostWrite(16'h0030, 16'h0000);
    chk("R11 resume ignored in ident", mode, 4);
    hostWrite(16'h00B0, 16'h0000);
    chk("R11 suspend ignored in ident", mode, 4);
    hostWrite(16'h00A0, 16'h0000);
    chk("R11 program ignored in ident", mode, 4);
    repeat (5) @(negedge clk);
    hostWrite(16'h00F0, 16'h0000);
    chk("R10 ident exit to suspend", mode, 3);
    hostWrite(16'h0030, 16'h0000);
    chk("R6 resume after ident", mode, 2);
    waitProgEnd(n);
    chk("R5 timer frozen through ident", n, N - 1);
  endtask

  task automatic tCoincide();
    startProgram(16'h5555, 16'h0040);
    repeat (N - 1) @(negedge clk);
    chk("R12 still programming", mode, 2);
    hostWrite(16'h00B0, 16'h0000);
    chk("R12 completion beats suspend", mode, 0);
  endtask

  task automatic tResetPending();
    startProgram(16'h6666, 16'h0050);
    hostWrite(16'h00B0, 16'h0000);
    doReset();
    chk("R1 reset from suspend", mode, 0);
    hostWrite(16'h0030, 16'h0000);
    chk("R1 no pending op", mode, 0);
    chk("R1 progEn after reset", progEn, 0);
  endtask

  initial begin
    doReset();
    tReset();
    tPlain();
    tSuspend();
    tRepeatResume();
    tAlternate();
    tIgnoreRead();
    tIdent();
    tCoincide();
    tResetPending();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule